// File: doc/BRIEF.md
# Dual-Channel Phase-Coded Pulse Generator

This block sets the transmit timing of a dual-polarization radar and gives, for every pulse, the baseband envelope and the inter-pulse phase word of the horizontal (H) and the vertical (V) channel. A downstream upconverter consumes these. An internal interval counter emits a one-clock trigger at the start of each pulse repetition interval. The interval is fixed, alternates between two values on successive pulses, or alternates between the two values in blocks of pulses.

Each channel reads its phase word from its own 64-entry code table, which the host fills. A shared pulse counter indexes both tables and wraps at a programmable last index. The envelope holds 32 samples and plays out one sample per clock from the trigger. Its shape is either a Gaussian-like taper, which keeps spectral sidelobes down, or a flat top. A polarization mode picks which channels radiate, and can step through V, then H, then both. The trigger comes with the pulse index and the polarization flags, so receive data can be tagged.

The host writes all settings through one write port. Mode and interval settings are held in pending registers and only take hold at the next pulse boundary.

Top module: `pgen_top`

## Requirements
- R1: `trig` is high for exactly one clock. The first trigger is in the first cycle after reset is released. In fixed mode (register 0x00 bits [1:0] = 0), triggers are spaced by interval A: register 0x01 bits [19:0], default 100 clocks.
- R2: In staggered mode (register 0x00 bits [1:0] = 1), intervals alternate A, B, A, B. The first pulse under the newly applied mode uses A. Interval B is register 0x02 bits [19:0], default 150.
- R3: In block-staggered mode (register 0x00 bits [1:0] = 2), the schedule gives N intervals of A, then N of B, and repeats. N is register 0x04 bits [7:0] plus one. The first block after the mode is applied uses A.
- R4: An interval value below 32 is raised to 32 clocks.
- R5: A write to registers 0x00 to 0x04 takes effect at the next pulse boundary. The interval and the envelope of the pulse in progress are unchanged.
- R6: `phaseH` is H-table entry i (address 0x40+i) and `phaseV` is V-table entry i (address 0x80+i), where i is `pulseIdx`. Entries are written from `wrData[11:0]`, and both words hold from one trigger until the next.
- R7: `pulseIdx` advances by one per pulse and returns to 0 after the last index, which is register 0x03 bits [5:0] (default 63).
- R8: With flat shape (register 0x00 bit 2 = 0), the envelope is 4095 in the trigger cycle and the 31 cycles after it, and 0 from then until the next trigger.
- R9: With Gaussian shape (bit 2 = 1), sample k (0..31, k = 0 in the trigger cycle) is floor(4095*2^24/D). Here u = 2k-31, y = u*u, and D = 2^24 + y*2^16 + y*y*128 + floor(y*y*y/6).
- R10: Register 0x00 bits [4:3] select polarization: 0 both, 1 H only, 2 V only, 3 the repeating sequence V, H, both, which starts with V when that mode is applied. A channel whose flag is low has a zero envelope. At each trigger at least one flag is high.
- R11: During reset `trig`, `pulseIdx`, `txH`, `txV`, both phase words and both envelopes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 8 | Host write address |
| wrData | input | 32 | Host write data |
| trig | output | 1 | One-clock pulse start strobe |
| pulseIdx | output | 6 | Index of the current pulse |
| txH | output | 1 | H channel radiates this pulse |
| txV | output | 1 | V channel radiates this pulse |
| phaseH | output | 12 | H phase word, 4096 steps per turn |
| phaseV | output | 12 | V phase word, 4096 steps per turn |
| envH | output | 12 | H envelope sample |
| envV | output | 12 | V envelope sample |

## Verification
The hardest situation to reach is a write landing in the middle of a pulse. That write must leave the running interval and envelope untouched and still govern the next pulse. The stimulus syncs to a trigger, writes a new shape and a new interval a known number of clocks later, and samples the envelope before the next boundary. It then measures the gap still to run and the gap that follows. Mode changes are also made from a state where the alternation flag or sequence step is mid-cycle, to show that each new schedule starts at its first element.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int PHASE_W = 12;
  localparam int IDX_W   = 6;
  localparam int TAB_LEN = 1 << IDX_W;
  localparam int PRT_W   = 20;
  localparam int BLK_W   = 8;
  localparam int ENV_W   = 12;
  localparam int ENV_AW  = 5;
  localparam int ENV_LEN = 1 << ENV_AW;

  localparam logic [7:0] ADDR_MODE  = 8'h00;
  localparam logic [7:0] ADDR_PRTA  = 8'h01;
  localparam logic [7:0] ADDR_PRTB  = 8'h02;
  localparam logic [7:0] ADDR_LAST  = 8'h03;
  localparam logic [7:0] ADDR_BLOCK = 8'h04;

  typedef enum logic [1:0] {PRT_FIXED, PRT_STAGGER, PRT_BLOCK, PRT_RSVD} prt_mode_e;
  typedef enum logic [1:0] {POL_BOTH, POL_H, POL_V, POL_SEQ} pol_mode_e;

  // strobes and per-pulse settings handed from control to datapath
  typedef struct packed {
    logic             start;
    logic             gauss;
    logic             txH;
    logic             txV;
    logic [IDX_W-1:0] idx;
  } pulse_cmd_t;

  // Gaussian-like taper: reciprocal of a truncated exp series, integer only
  function automatic logic [ENV_W-1:0] gaussSample(input int k);
    longint u, y, den, full;
    u    = longint'(2 * k - (ENV_LEN - 1));
    y    = u * u;
    den  = 64'sd16777216 + y * 64'sd65536 + y * y * 64'sd128 + (y * y * y) / 64'sd6;
    full = (64'sd1 <<< ENV_W) - 64'sd1;
    return ENV_W'((full * 64'sd16777216) / den);
  endfunction
endpackage

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
  import pgen_pkg::*;
#(
  parameter int PRT_A_DEF = 100,
  parameter int PRT_B_DEF = 150,
  parameter int BLK_DEF   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrAddr,
  input  logic [31:0]      wrData,
  output pulse_cmd_t       cmd,
  output logic             trig,
  output logic [IDX_W-1:0] pulseIdx,
  output logic             txH,
  output logic             txV
);
  localparam logic [PRT_W-1:0] MIN_LEN = PRT_W'(ENV_LEN);

  prt_mode_e        prtModeQ, lastPrtQ;
  pol_mode_e        polModeQ, lastPolQ;
  logic             shapeQ;
  logic [PRT_W-1:0] prtAQ, prtBQ, cntQ, rawLen, len;
  logic [IDX_W-1:0] lastIdxQ, nxtIdxQ;
  logic [BLK_W-1:0] blkLastQ, blkQ, curBlk;
  logic             useBQ, curB, restartPrt, boundary;
  logic [1:0]       stepQ, curStep;
  logic             txHNext, txVNext;

  // pending settings, sampled only at a pulse boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prtModeQ <= PRT_FIXED;
      polModeQ <= POL_BOTH;
      shapeQ   <= 1'b0;
      prtAQ    <= PRT_W'(PRT_A_DEF);
      prtBQ    <= PRT_W'(PRT_B_DEF);
      lastIdxQ <= '1;
      blkLastQ <= BLK_W'(BLK_DEF);
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_MODE: begin
          prtModeQ <= prt_mode_e'(wrData[1:0]);
          shapeQ   <= wrData[2];
          polModeQ <= pol_mode_e'(wrData[4:3]);
        end
        ADDR_PRTA:  prtAQ    <= wrData[PRT_W-1:0];
        ADDR_PRTB:  prtBQ    <= wrData[PRT_W-1:0];
        ADDR_LAST:  lastIdxQ <= wrData[IDX_W-1:0];
        ADDR_BLOCK: blkLastQ <= wrData[BLK_W-1:0];
        default: ;
      endcase
    end
  end

  assign boundary   = (cntQ == '0);
  assign restartPrt = (prtModeQ != lastPrtQ);
  assign curB       = !restartPrt && useBQ;
  assign curBlk     = restartPrt ? '0 : blkQ;
  assign rawLen     = ((prtModeQ == PRT_STAGGER || prtModeQ == PRT_BLOCK) && curB) ? prtBQ : prtAQ;
  assign len        = (rawLen < MIN_LEN) ? MIN_LEN : rawLen;
  assign curStep    = (polModeQ != lastPolQ) ? 2'd0 : stepQ;

  always_comb begin
    txHNext = 1'b1;
    txVNext = 1'b1;
    case (polModeQ)
      POL_H: txVNext = 1'b0;
      POL_V: txHNext = 1'b0;
      POL_SEQ: begin
        if (curStep == 2'd0)      txHNext = 1'b0;
        else if (curStep == 2'd1) txVNext = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      nxtIdxQ  <= '0;
      useBQ    <= 1'b0;
      blkQ     <= '0;
      lastPrtQ <= PRT_FIXED;
      lastPolQ <= POL_BOTH;
      stepQ    <= '0;
      trig     <= 1'b0;
      pulseIdx <= '0;
      txH      <= 1'b0;
      txV      <= 1'b0;
    end else if (boundary) begin
      cntQ     <= len - 1'b1;
      nxtIdxQ  <= (nxtIdxQ >= lastIdxQ) ? '0 : nxtIdxQ + 1'b1;
      lastPrtQ <= prtModeQ;
      lastPolQ <= polModeQ;
      stepQ    <= (curStep == 2'd2) ? 2'd0 : curStep + 2'd1;
      trig     <= 1'b1;
      pulseIdx <= nxtIdxQ;
      txH      <= txHNext;
      txV      <= txVNext;
      case (prtModeQ)
        PRT_STAGGER: begin
          useBQ <= !curB;
          blkQ  <= '0;
        end
        PRT_BLOCK: begin
          if (curBlk == blkLastQ) begin
            useBQ <= !curB;
            blkQ  <= '0;
          end else begin
            useBQ <= curB;
            blkQ  <= curBlk + 1'b1;
          end
        end
        default: begin
          useBQ <= 1'b0;
          blkQ  <= '0;
        end
      endcase
    end else begin
      cntQ <= cntQ - 1'b1;
      trig <= 1'b0;
    end
  end

  assign cmd.start = boundary;
  assign cmd.gauss = shapeQ;
  assign cmd.txH   = txHNext;
  assign cmd.txV   = txVNext;
  assign cmd.idx   = nxtIdxQ;
endmodule

// File: rtl/pgen_dpath.sv
module pgen_dpath
  import pgen_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [7:0]         wrAddr,
  input  logic [31:0]        wrData,
  input  pulse_cmd_t         cmd,
  output logic [PHASE_W-1:0] phaseH,
  output logic [PHASE_W-1:0] phaseV,
  output logic [ENV_W-1:0]   envH,
  output logic [ENV_W-1:0]   envV
);
  localparam int NCH = 2;

  logic [ENV_W-1:0]   gaussTab [ENV_LEN];
  logic [ENV_AW-1:0]  sampQ, selSamp;
  logic               busyQ, gaussQ, selGauss;
  logic [ENV_W-1:0]   envQ, shapeNow;
  logic [NCH-1:0]     txVec, chEnQ;
  logic [PHASE_W-1:0] phaseQ [NCH];
  logic [ENV_W-1:0]   envCh  [NCH];

  for (genvar k = 0; k < ENV_LEN; k++) begin : g_gauss
    assign gaussTab[k] = gaussSample(k);
  end

  assign selSamp  = cmd.start ? '0 : sampQ;
  assign selGauss = cmd.start ? cmd.gauss : gaussQ;
  assign shapeNow = selGauss ? gaussTab[selSamp] : '1;

  // shared envelope playback, one sample per clock from the boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      sampQ  <= '0;
      gaussQ <= 1'b0;
      envQ   <= '0;
    end else if (cmd.start) begin
      busyQ  <= 1'b1;
      sampQ  <= ENV_AW'(1);
      gaussQ <= cmd.gauss;
      envQ   <= shapeNow;
    end else if (busyQ) begin
      envQ  <= shapeNow;
      sampQ <= sampQ + 1'b1;
      if (sampQ == ENV_AW'(ENV_LEN - 1)) busyQ <= 1'b0;
    end else begin
      envQ <= '0;
    end
  end

  assign txVec = {cmd.txV, cmd.txH};

  // channel 0 = H (table at 0x40), channel 1 = V (table at 0x80)
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [PHASE_W-1:0] tabQ [TAB_LEN];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < TAB_LEN; i++) tabQ[i] <= '0;
      end else if (wrEn && wrAddr[7:6] == 2'(ch + 1)) begin
        tabQ[wrAddr[IDX_W-1:0]] <= wrData[PHASE_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        phaseQ[ch] <= '0;
        chEnQ[ch]  <= 1'b0;
      end else if (cmd.start) begin
        phaseQ[ch] <= tabQ[cmd.idx];
        chEnQ[ch]  <= txVec[ch];
      end
    end

    assign envCh[ch] = chEnQ[ch] ? envQ : '0;
  end

  assign phaseH = phaseQ[0];
  assign phaseV = phaseQ[1];
  assign envH   = envCh[0];
  assign envV   = envCh[1];
endmodule

// File: rtl/pgen_top.sv
module pgen_top
  import pgen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrAddr,
  input  logic [31:0] wrData,
  output logic        trig,
  output logic [5:0]  pulseIdx,
  output logic        txH,
  output logic        txV,
  output logic [11:0] phaseH,
  output logic [11:0] phaseV,
  output logic [11:0] envH,
  output logic [11:0] envV
);
  pulse_cmd_t cmd;

  pgen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmd(cmd), .trig(trig), .pulseIdx(pulseIdx), .txH(txH), .txV(txV)
  );

  pgen_dpath u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmd(cmd), .phaseH(phaseH), .phaseV(phaseV), .envH(envH), .envV(envV)
  );
endmodule

// File: rtl/pgen_checks.sv
module pgen_checks
  import pgen_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        trig,
  input logic [5:0]  pulseIdx,
  input logic        txH,
  input logic        txV,
  input logic [11:0] phaseH,
  input logic [11:0] phaseV,
  input logic [11:0] envH,
  input logic [11:0] envV
);
  // cycles since the last trigger, saturating at the envelope length
  int gapQ;
  always_ff @(posedge clk) begin
    if (!rstN)                gapQ <= ENV_LEN;
    else if (trig)            gapQ <= 1;
    else if (gapQ < ENV_LEN)  gapQ <= gapQ + 1;
  end

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> !trig);
  a_r4_min_spacing: assert property (@(posedge clk) disable iff (!rstN)
    trig |-> gapQ >= ENV_LEN);
  a_r8_env_window: assert property (@(posedge clk) disable iff (!rstN)
    (!trig && gapQ >= ENV_LEN) |-> (envH == '0 && envV == '0));
  a_r10_gate_h: assert property (@(posedge clk) disable iff (!rstN)
    !txH |-> envH == '0);
  a_r10_gate_v: assert property (@(posedge clk) disable iff (!rstN)
    !txV |-> envV == '0);
  a_r10_active: assert property (@(posedge clk) disable iff (!rstN)
    trig |-> (txH || txV));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !trig |-> ($stable(phaseH) && $stable(phaseV) && $stable(pulseIdx)));
endmodule

bind pgen_top pgen_checks u_checks (
  .clk(clk), .rstN(rstN), .trig(trig), .pulseIdx(pulseIdx), .txH(txH), .txV(txV),
  .phaseH(phaseH), .phaseV(phaseV), .envH(envH), .envV(envV)
);

// File: tb/pgen_top_bench.sv
`timescale 1ns/1ps
module pgen_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        trig, txH, txV;
  logic [5:0]  pulseIdx;
  logic [11:0] phaseH, phaseV, envH, envV;

  int checks = 0;
  int errors = 0;
  logic [11:0] expH [4];
  logic [11:0] expV [4];

  pgen_top u_pgen_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .trig(trig), .pulseIdx(pulseIdx), .txH(txH), .txV(txV),
    .phaseH(phaseH), .phaseV(phaseV), .envH(envH), .envV(envV)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic nextTrig(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!trig && n < 5000);
    if (!trig) check(1'b0, "watchdog no trigger", n, 0);
  endtask

  function automatic int gaussExp(input int k);
    longint u, y, d;
    u = 2 * k - 31;
    y = u * u;
    d = 64'sd16777216 + y * 65536 + y * y * 128 + (y * y * y) / 6;
    return int'((64'sd4095 * 64'sd16777216) / d);
  endfunction

  task automatic testReset;
    repeat (3) @(negedge clk);
    check(trig == 0 && pulseIdx == 0, "R11 trig/index in reset", {trig, pulseIdx}, 0);
    check(txH == 0 && txV == 0, "R11 flags in reset", {txH, txV}, 0);
    check(phaseH == 0 && phaseV == 0, "R11 phases in reset", {phaseH, phaseV}, 0);
    check(envH == 0 && envV == 0, "R11 envelopes in reset", {envH, envV}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(trig == 1, "R1 first trigger after reset", trig, 1);
  endtask

  task automatic testFixed;
    int g;
    check(envH == 4095 && envV == 4095, "R8 default flat, both channels", envH, 4095);
    @(negedge clk);
    check(trig == 0, "R1 strobe one clock", trig, 0);
    nextTrig(g);
    check(g == 99, "R1 default interval", g, 99);
    nextTrig(g);
    check(g == 100, "R1 default interval", g, 100);
  endtask

  task automatic testEnvRect;
    for (int k = 0; k <= 32; k++) begin
      if (k > 0) @(negedge clk);
      check(envH == ((k < 32) ? 12'd4095 : 12'd0), "R8 flat sample", envH, (k < 32) ? 4095 : 0);
    end
  endtask

  task automatic testPhase;
    int g;
    logic [5:0] prev;
    nextTrig(g);
    regWrite(8'h03, 32'd3);
    for (int i = 0; i < 4; i++) begin
      expH[i] = 12'((i * 713 + 91) & 12'hFFF);
      expV[i] = 12'((4095 - i * 389) & 12'hFFF);
      regWrite(8'h40 + 8'(i), {20'd0, expH[i]});
      regWrite(8'h80 + 8'(i), {20'd0, expV[i]});
    end
    nextTrig(g);
    prev = pulseIdx;
    for (int p = 0; p < 6; p++) begin
      nextTrig(g);
      check(pulseIdx == ((prev >= 3) ? 6'd0 : prev + 6'd1), "R7 index step and wrap",
            pulseIdx, (prev >= 3) ? 0 : prev + 1);
      check(phaseH == expH[pulseIdx[1:0]], "R6 H phase from H table", phaseH, expH[pulseIdx[1:0]]);
      check(phaseV == expV[pulseIdx[1:0]], "R6 V phase from V table", phaseV, expV[pulseIdx[1:0]]);
      prev = pulseIdx;
    end
  endtask

  task automatic testBoundary;
    int g;
    nextTrig(g);
    regWrite(8'h00, 32'h4);
    check(envH == 4095, "R5 running pulse keeps flat shape", envH, 4095);
    regWrite(8'h01, 32'd50);
    nextTrig(g);
    check(g == 96, "R5 running interval unchanged", g, 96);
    for (int k = 0; k <= 32; k++) begin
      if (k > 0) @(negedge clk);
      check(envH == 12'((k < 32) ? gaussExp(k) : 0), "R9 Gaussian sample", envH,
            (k < 32) ? gaussExp(k) : 0);
    end
    nextTrig(g);
    check(g == 18, "R5 new interval applied", g, 18);
  endtask

  task automatic testStagger;
    int g;
    regWrite(8'h01, 32'd40);
    regWrite(8'h02, 32'd70);
    regWrite(8'h00, 32'd1);
    nextTrig(g);
    for (int p = 0; p < 4; p++) begin
      nextTrig(g);
      check(g == ((p % 2 == 0) ? 40 : 70), "R2 staggered gap", g, (p % 2 == 0) ? 40 : 70);
    end
  endtask

  task automatic testBlock;
    int g;
    int e;
    regWrite(8'h04, 32'd1);
    regWrite(8'h00, 32'd2);
    nextTrig(g);
    for (int p = 0; p < 6; p++) begin
      nextTrig(g);
      e = ((p / 2) % 2 == 0) ? 40 : 70;
      check(g == e, "R3 block-staggered gap", g, e);
    end
  endtask

  task automatic testClamp;
    int g;
    regWrite(8'h01, 32'd5);
    regWrite(8'h00, 32'd0);
    nextTrig(g);
    for (int p = 0; p < 2; p++) begin
      nextTrig(g);
      check(g == 32, "R4 short interval raised", g, 32);
    end
  endtask

  task automatic checkPol(input bit eH, input bit eV, input string req);
    check(txH == eH && txV == eV, req, {txH, txV}, {eH, eV});
    check(envH == (eH ? 12'd4095 : 12'd0), req, envH, eH ? 4095 : 0);
    check(envV == (eV ? 12'd4095 : 12'd0), req, envV, eV ? 4095 : 0);
  endtask

  task automatic testPol;
    int g;
    regWrite(8'h00, 32'd24);
    nextTrig(g);
    checkPol(1'b0, 1'b1, "R10 sequence V");
    nextTrig(g);
    checkPol(1'b1, 1'b0, "R10 sequence H");
    nextTrig(g);
    checkPol(1'b1, 1'b1, "R10 sequence both");
    nextTrig(g);
    checkPol(1'b0, 1'b1, "R10 sequence repeats V");
    regWrite(8'h00, 32'd8);
    nextTrig(g);
    checkPol(1'b1, 1'b0, "R10 H only");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset;
    testFixed;
    testEnvRect;
    testPhase;
    testBoundary;
    testStagger;
    testBlock;
    testClamp;
    testPol;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule